// File: doc/BRIEF.md
# Mode-Qualified Dual Performance Counter

This block keeps two 32-bit event counters for processor performance monitoring. Each counter has a control word that picks one of sixteen event strobes from that counter's own strobe vector. The control word also holds an overflow interrupt enable and four processor-mode qualifier bits. On each clock the counter adds one if its selected strobe is high and the current processor mode is one that its qualifiers allow.

The processor mode falls into one of four classes: user, supervisor, plain kernel, and kernel while handling an exception (exception level set). When the error level is set and the exception level is clear, no class matches and nothing is counted. Software reads and writes both counters and both control words through a small synchronous register port. A write to a counter wins over an increment in the same cycle. When a counter's top bit is 1 and its interrupt enable is set, the shared interrupt output is high. The output stays high until software rewrites that counter or clears the enable.

The block only receives event strobes; it does not generate them. Interrupt prioritisation happens outside the block.

Top module: `perf_counter_pair`

## Requirements
- R1: After reset, both counters and both control words read zero and `ovf_irq` is low.
- R2: Counter A increments by exactly one on a clock edge where `ev_a[sel]` is high and the mode qualifies, where sel is control bits [3:0]. Counter B does the same with `ev_b`. A counter never reacts to the other counter's strobe vector, so the same selector on both counters counts different events.
- R3: Control bit 5 (user qualifier) allows counting when `mode_user` is high and `mode_exl` and `mode_erl` are low.
- R4: Control bit 6 (supervisor qualifier) allows counting when `mode_super` is high and `mode_user`, `mode_exl` and `mode_erl` are low.
- R5: Control bit 7 (kernel qualifier) allows counting only when all four mode inputs are low.
- R6: Control bit 8 (exception qualifier) allows counting when `mode_exl` is high, whatever the other mode inputs are. Under `mode_exl` the other qualifier bits have no effect.
- R7: When `mode_erl` is high and `mode_exl` is low, neither counter changes except by a register write.
- R8: A register write to a counter loads `reg_wdata` on that edge, even if an increment would also happen in that cycle.
- R9: `ovf_irq` equals the OR, over both counters, of control bit 4 (interrupt enable) AND counter bit 31. It goes high the cycle after a counter steps from 0x7FFFFFFF to 0x80000000. It drops after software writes a value with bit 31 clear.
- R10: Register addresses are: 0 = control A, 1 = counter A, 2 = control B, 3 = counter B. `reg_rdata` follows `reg_addr` in the same cycle. Control bits 31:9 are not stored and read as zero.
- R11: A counter at 0xFFFFFFFF that increments wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (see R10) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_a | input | 16 | One-cycle event strobes for counter A |
| ev_b | input | 16 | One-cycle event strobes for counter B |
| mode_user | input | 1 | Processor in user mode |
| mode_super | input | 1 | Processor in supervisor mode |
| mode_exl | input | 1 | Exception level set |
| mode_erl | input | 1 | Error level set |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
If the mode class or the event selection is wrong inside the block, a counter's read value drifts from the reference. This shows up on the first clock edge after the faulty increment or missed increment, whenever that counter is addressed. The bench cycles the address so that every register appears on `reg_rdata` within a few cycles. Faulty overflow logic shows as a wrong `ovf_irq` one cycle after bit 31 changes. Faulty write priority shows as a counter value that is one too high right after the write.

// File: rtl/pcnt_pkg.sv
// Package: shared control-word layout and mode classes for the counter pair.
// Assumes a 4-bit selector, so every counter has 16 event strobes.
package pcnt_pkg;
    localparam int SEL_W  = 4;
    localparam int EV_N   = 1 << SEL_W;
    localparam int CTRL_W = SEL_W + 5;

    // Control word, high bit first: exc, kernel, super, user, irq enable, selector
    typedef struct packed {
        logic             q_exc;
        logic             q_krn;
        logic             q_sup;
        logic             q_usr;
        logic             irq_en;
        logic [SEL_W-1:0] sel;
    } pcnt_ctrl_t;

    typedef enum logic [2:0] {
        MC_USER  = 3'd0,
        MC_SUPER = 3'd1,
        MC_KERN  = 3'd2,
        MC_EXC   = 3'd3,
        MC_NONE  = 3'd4
    } pcnt_mode_e;
endpackage

// File: rtl/pcnt_mode_class.sv
// Module: turns the four raw mode inputs into one mode class.
// Assumes the exception level overrides everything else. With only the
// error level set, no class applies.
module pcnt_mode_class
    import pcnt_pkg::*;
(
    input  logic       m_user,
    input  logic       m_super,
    input  logic       m_exl,
    input  logic       m_erl,
    output pcnt_mode_e mclass
);
    // Priority decode of the mode inputs
    always_comb begin
        if (m_exl)        mclass = MC_EXC;
        else if (m_erl)   mclass = MC_NONE;
        else if (m_user)  mclass = MC_USER;
        else if (m_super) mclass = MC_SUPER;
        else              mclass = MC_KERN;
    end
endmodule

// File: rtl/pcnt_slot.sv
// Module: one counter and its control word.
// Assumes the one-cycle strobes are synchronous to clk. A counter write
// wins over an increment in the same cycle.
module pcnt_slot
    import pcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic [EV_N-1:0]  events,
    input  pcnt_mode_e       mclass,
    output pcnt_ctrl_t       ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);
    logic mode_ok;
    logic bump;

    // Check the current mode class against the qualifier bits
    always_comb begin
        unique case (mclass)
            MC_USER:  mode_ok = ctrl_q.q_usr;
            MC_SUPER: mode_ok = ctrl_q.q_sup;
            MC_KERN:  mode_ok = ctrl_q.q_krn;
            MC_EXC:   mode_ok = ctrl_q.q_exc;
            default:  mode_ok = 1'b0;
        endcase
    end

    assign bump = events[ctrl_q.sel] & mode_ok;
    assign ovf  = ctrl_q.irq_en & cnt_q[CNT_W-1];

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= pcnt_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Counter register: a write wins over an increment
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= wdata;
        else if (bump)   cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/perf_counter_pair.sv
// Module: top of the two mode-qualified performance counters.
// Assumes a register address of {slot, is_counter}. Reads are
// combinational. The overflow request is the OR of the enabled top bits.
module perf_counter_pair
    import pcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [EV_N-1:0]  ev_a,
    input  logic [EV_N-1:0]  ev_b,
    input  logic             mode_user,
    input  logic             mode_super,
    input  logic             mode_exl,
    input  logic             mode_erl,
    output logic             ovf_irq
);
    localparam int NSLOT = 2;

    pcnt_mode_e       mclass;
    pcnt_ctrl_t       ctrl_q [NSLOT];
    logic [CNT_W-1:0] cnt_q  [NSLOT];
    logic [NSLOT-1:0] ovf_v;
    logic [EV_N-1:0]  ev_v   [NSLOT];

    assign ev_v[0] = ev_a;
    assign ev_v[1] = ev_b;

    pcnt_mode_class u_mclass (
        .m_user  (mode_user),
        .m_super (mode_super),
        .m_exl   (mode_exl),
        .m_erl   (mode_erl),
        .mclass  (mclass)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        pcnt_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (reg_wr && reg_addr == {k[0], 1'b0}),
            .cnt_we  (reg_wr && reg_addr == {k[0], 1'b1}),
            .wdata   (reg_wdata),
            .events  (ev_v[k]),
            .mclass  (mclass),
            .ctrl_q  (ctrl_q[k]),
            .cnt_q   (cnt_q[k]),
            .ovf     (ovf_v[k])
        );
    end

    // Read mux: counter or zero-extended control word
    always_comb begin
        if (reg_addr[0]) reg_rdata = cnt_q[reg_addr[1]];
        else             reg_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q[reg_addr[1]]};
    end

    assign ovf_irq = |ovf_v;
endmodule

// File: rtl/pcnt_checker.sv
// Module: temporal checks for perf_counter_pair, attached by bind.
// Assumes the address map {slot, is_counter}.
module pcnt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic             mode_exl,
    input logic             mode_erl,
    input logic [8:0]       ctrl0,
    input logic [8:0]       ctrl1,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic             irq
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    logic wr_c0, wr_c1;
    assign wr_c0 = reg_wr && reg_addr == 2'b01;
    assign wr_c1 = reg_wr && reg_addr == 2'b11;

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c0 |=> cnt0 == $past(reg_wdata));

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_c1 |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) + ONE));

    p_erl_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_erl && !mode_exl && !wr_c0) |=> cnt0 == $past(cnt0));

    p_erl_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_erl && !mode_exl && !wr_c1) |=> cnt1 == $past(cnt1));

    p_irq_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> (irq == $past(irq) || cnt0[CNT_W-1] != $past(cnt0[CNT_W-1])
                     || cnt1[CNT_W-1] != $past(cnt1[CNT_W-1])));

    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(ctrl0) && $stable(ctrl1)));
endmodule

bind perf_counter_pair pcnt_checker #(.CNT_W(CNT_W)) u_pcnt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode_exl  (mode_exl),
    .mode_erl  (mode_erl),
    .ctrl0     (ctrl_q[0]),
    .ctrl1     (ctrl_q[1]),
    .cnt0      (cnt_q[0]),
    .cnt1      (cnt_q[1]),
    .irq       (ovf_irq)
);

// File: tb/test_perf_counter_pair.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model that is compared with the outputs on every cycle.
module test_perf_counter_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] ev_a = '0, ev_b = '0;
    logic        mode_user = 1'b0, mode_super = 1'b0, mode_exl = 1'b0, mode_erl = 1'b0;
    logic        ovf_irq;

    int n_tests = 0;
    int n_fail  = 0;
    string tag = "R1";
    bit done = 1'b0;

    // Reference state
    logic [31:0] m_cnt [2];
    logic [8:0]  m_ctl [2];

    always #4 clk = ~clk;

    perf_counter_pair i_perf_counter_pair (.*);

    function automatic bit qual(logic [8:0] c);
        if (mode_exl)   return c[8];
        if (mode_erl)   return 1'b0;
        if (mode_user)  return c[5];
        if (mode_super) return c[6];
        return c[7];
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: update the model from the held inputs, then compare at the negedge
    task automatic cyc();
        logic [31:0] exp_rd;
        logic        exp_irq;
        @(posedge clk);
        if (!rst_n) begin
            m_cnt[0] = '0; m_cnt[1] = '0; m_ctl[0] = '0; m_ctl[1] = '0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                logic [15:0] ev;
                bit step;
                ev = (k == 0) ? ev_a : ev_b;
                step = ev[m_ctl[k][3:0]] && qual(m_ctl[k]);
                if (reg_wr && reg_addr == {k[0], 1'b1}) m_cnt[k] = reg_wdata;
                else if (step) m_cnt[k] = m_cnt[k] + 1;
                if (reg_wr && reg_addr == {k[0], 1'b0}) m_ctl[k] = reg_wdata[8:0];
            end
        end
        @(negedge clk);
        exp_rd  = reg_addr[0] ? m_cnt[reg_addr[1]] : {23'd0, m_ctl[reg_addr[1]]};
        exp_irq = (m_ctl[0][4] & m_cnt[0][31]) | (m_ctl[1][4] & m_cnt[1][31]);
        check(reg_rdata === exp_rd, tag, reg_rdata, exp_rd);
        check(ovf_irq === exp_irq, "R9", {31'd0, ovf_irq}, {31'd0, exp_irq});
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic set_mode(bit u, bit s, bit x, bit r);
        mode_user = u; mode_super = s; mode_exl = x; mode_erl = r;
    endtask

    // Hold the strobes for n cycles and read the addressed register
    task automatic run(logic [15:0] a, logic [15:0] b, logic [1:0] rd, int n);
        ev_a = a; ev_b = b; reg_addr = rd;
        for (int i = 0; i < n; i++) cyc();
        ev_a = '0; ev_b = '0;
    endtask

    initial begin
        #(200000 * 8);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;
        // R1: reset state at every address
        tag = "R1";
        for (int a = 0; a < 4; a++) begin reg_addr = 2'(a); cyc(); end

        // R2: same selector on both counters, separate strobe vectors
        tag = "R2";
        set_mode(1, 0, 0, 0);
        wr(2'd0, 32'h21); wr(2'd2, 32'h21);
        run(16'h0002, 16'h0000, 2'd1, 3);
        run(16'h0000, 16'h0000, 2'd3, 1);
        check(reg_rdata == 0, "R2", reg_rdata, 0);
        wr(2'd0, 32'h2F); wr(2'd2, 32'h2F);
        run(16'h0000, 16'h8000, 2'd3, 4);
        run(16'h0000, 16'h0000, 2'd1, 1);
        check(reg_rdata == 3, "R2", reg_rdata, 3);

        // R3..R6: each qualifier bit alone, in each mode
        for (int q = 5; q <= 8; q++) begin
            wr(2'd0, 32'(1 << q));
            for (int md = 0; md < 4; md++) begin
                tag = (q == 5) ? "R3" : (q == 6) ? "R4" : (q == 7) ? "R5" : "R6";
                set_mode(md == 0, md == 1, md == 3, 0);
                run(16'h0001, 16'h0001, 2'd1, 2);
            end
        end
        // R6: the exception level overrides the other inputs
        tag = "R6";
        wr(2'd0, 32'h0E0);
        set_mode(1, 1, 1, 1);
        run(16'h0001, 16'h0000, 2'd1, 3);
        wr(2'd0, 32'h100);
        run(16'h0001, 16'h0000, 2'd1, 3);

        // R7: error level only, every qualifier on
        tag = "R7";
        wr(2'd0, 32'h1E0); wr(2'd2, 32'h1E0);
        set_mode(1, 0, 0, 1);
        run(16'hFFFF, 16'hFFFF, 2'd1, 4);
        run(16'hFFFF, 16'hFFFF, 2'd3, 4);

        // R8: a write wins over a simultaneous event
        tag = "R8";
        set_mode(0, 0, 0, 0);
        ev_a = 16'hFFFF;
        wr(2'd1, 32'h0000_1234);
        reg_addr = 2'd1; ev_a = '0; cyc();
        check(reg_rdata == 32'h1234, "R8", reg_rdata, 32'h1234);

        // R9: overflow into bit 31 with the enable on, then clear by rewrite
        tag = "R9";
        wr(2'd0, 32'h090);
        wr(2'd1, 32'h7FFF_FFFE);
        run(16'h0001, 16'h0000, 2'd1, 3);
        check(ovf_irq == 1'b1, "R9", {31'd0, ovf_irq}, 1);
        wr(2'd1, 32'h0);
        check(ovf_irq == 1'b0, "R9", {31'd0, ovf_irq}, 0);
        wr(2'd2, 32'h001); wr(2'd3, 32'h8000_0000);
        check(ovf_irq == 1'b0, "R9", {31'd0, ovf_irq}, 0);
        wr(2'd2, 32'h011);
        check(ovf_irq == 1'b1, "R9", {31'd0, ovf_irq}, 1);
        wr(2'd3, 32'h5);

        // R10: unused control bits read as zero
        tag = "R10";
        wr(2'd2, 32'hFFFF_FFFF);
        reg_addr = 2'd2; cyc();
        check(reg_rdata == 32'h1FF, "R10", reg_rdata, 32'h1FF);

        // R11: wrap from all ones
        tag = "R11";
        wr(2'd0, 32'h080);
        wr(2'd1, 32'hFFFF_FFFF);
        run(16'h0001, 16'h0000, 2'd1, 2);
        check(reg_rdata == 32'h1, "R11", reg_rdata, 32'h1);

        // Mixed traffic, compared on every cycle
        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            reg_wr = ($urandom_range(0, 11) == 0);
            reg_addr = 2'($urandom_range(0, 3));
            reg_wdata = reg_addr[0] ? (32'h7FFF_FFF0 + 32'($urandom_range(0, 31)))
                                    : 32'($urandom_range(0, 511));
            ev_a = 16'($urandom); ev_b = 16'($urandom);
            set_mode($urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
            cyc();
        end
        reg_wr = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule